// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit takes the fields of an already decoded instruction (a 3-bit addressing mode, an 8-bit address field and a register selector), together with the program counter of that instruction. It forms the effective address and fetches the operand. The operand may come straight from the address field, from the register file, or from a synchronous single-port data memory after one or two reads. A one-cycle `done` pulse marks the moment when the effective address and operand outputs hold the result.

The unit has one combinational register-file read port. The file is read only in the cycle a request is accepted. The data memory returns the addressed word one cycle after a read strobe.

The number of memory reads depends on the mode:
- The address-field mode and the register mode need no memory access.
- The memory-indirect mode chains two reads. The first read fetches a full word-width pointer, and the second fetches the operand at that pointer.
- Every other mode performs exactly one read.

A new request is taken only while the unit is idle. A request presented while the unit is busy has no effect.

Top module: `opnd_addr_unit`

## Requirements
- R1: After reset, and at any time the unit is idle, `busy`, `done` and `mem_re` are all 0.
- R2: Mode code 0 (immediate) returns `operand` = the address field zero-extended to 16 bits and `ea` = 0. It makes no memory read, and `done` is high in the first cycle after acceptance.
- R3: Mode code 3 (register) returns `operand` = the selected register's value, sampled in the acceptance cycle, and `ea` = 0. It makes no memory read, and `done` is high in the first cycle after acceptance.
- R4: Mode code 1 (direct) uses `ea` = the zero-extended address field. It makes exactly one read at that address, `operand` is the word read, and `done` is high in the third cycle after acceptance.
- R5: Mode code 2 (indirect) first reads the word at the zero-extended address field. It then reads the operand at the address held in that word, so any 16-bit address is reachable. `ea` is that pointer, there are exactly two reads, and `done` is high in the fifth cycle after acceptance.
- R6: Mode code 4 (register indirect) uses `ea` = the selected register's value and makes one read for the operand. Its latency is the same as R4.
- R7: Mode code 5 (displacement) uses `ea` = register value plus the sign-extended address field, modulo 2^16. It makes one read for the operand.
- R8: Mode code 6 (PC-relative) uses `ea` = `req_pc` plus the sign-extended address field, modulo 2^16. It makes one read for the operand.
- R9: Mode code 7 (base register) uses `ea` = register value plus the zero-extended address field, modulo 2^16. It makes one read for the operand.
- R10: `done` lasts exactly one cycle, and the unit is idle in the cycle after it. A request presented while `busy` is 1 is ignored and does not change the result of the operation in flight.
- R11: `mem_re` is never high in two consecutive cycles. A memory read strobe is followed by one cycle in which the returned word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_mode | input | 3 | Addressing mode code (0..7, see R2-R9) |
| req_afield | input | 8 | Address field A |
| req_rsel | input | 3 | Register field R |
| req_pc | input | 16 | Program counter of the instruction |
| busy | output | 1 | Unit is processing a request |
| rf_rsel | output | 3 | Register-file read index |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| mem_re | output | 1 | Data-memory read strobe |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 16 | Data-memory read data, valid one cycle after `mem_re` |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address of the completed request |
| operand | output | 16 | Operand of the completed request |

## Verification
The assertions check the timing skeleton on every cycle:
- the unit is quiet while idle;
- `done` lasts a single cycle;
- read strobes are spaced apart;
- zero-access modes finish in one cycle and one-read modes strobe memory right after acceptance;
- the second indirect read goes to the word returned by the first.

The address arithmetic can only be shown by the bench's scenarios, which compare the unit cycle by cycle against a behavioural model. These scenarios cover the sign-extension and wrap of the displacement and relative sums against the zero-extension of the base mode, a pointer beyond the 8-bit field range, and requests dropped while busy.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef enum logic [2:0] {
    MD_IMM  = 3'd0,
    MD_DIR  = 3'd1,
    MD_IND  = 3'd2,
    MD_REG  = 3'd3,
    MD_RIND = 3'd4,
    MD_DISP = 3'd5,
    MD_REL  = 3'd6,
    MD_BASE = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_PTR = 3'd1,
    ST_WT_PTR = 3'd2,
    ST_RD_OP  = 3'd3,
    ST_WT_OP  = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  localparam int unsigned READS_W = 2;

endpackage

// File: rtl/oau_ea_calc.sv
module oau_ea_calc
  import oau_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic [2:0]         mode,
  input  logic [AW-1:0]      afield,
  input  logic [DW-1:0]      rval,
  input  logic [DW-1:0]      pc,
  output logic [DW-1:0]      first_addr,
  output logic [DW-1:0]      early_operand,
  output logic [READS_W-1:0] reads_needed
);

  localparam int unsigned EXT = DW - AW;

  function automatic logic [DW-1:0] zext_f(input logic [AW-1:0] a);
    return {{EXT{1'b0}}, a};
  endfunction

  function automatic logic [DW-1:0] sext_f(input logic [AW-1:0] a);
    return {{EXT{a[AW-1]}}, a};
  endfunction

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    return x + y;
  endfunction

  amode_e md;
  assign md = amode_e'(mode);

  always_comb begin
    first_addr    = '0;
    early_operand = '0;
    reads_needed  = 2'd1;
    unique case (md)
      MD_IMM: begin
        early_operand = zext_f(afield);
        reads_needed  = 2'd0;
      end
      MD_REG: begin
        early_operand = rval;
        reads_needed  = 2'd0;
      end
      MD_DIR:  first_addr = zext_f(afield);
      MD_IND: begin
        first_addr   = zext_f(afield);
        reads_needed = 2'd2;
      end
      MD_RIND: first_addr = rval;
      MD_DISP: first_addr = wrap_add(rval, sext_f(afield));
      MD_REL:  first_addr = wrap_add(pc, sext_f(afield));
      MD_BASE: first_addr = wrap_add(rval, zext_f(afield));
      default: first_addr = '0;
    endcase
  end

endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [READS_W-1:0] reads_needed,
  output logic               accept,
  output logic               issue,
  output logic               ptr_capture,
  output logic               op_capture,
  output logic               done,
  output logic               busy
);

  seq_state_e state_q, state_d;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (reads_needed)
            2'd0:    state_d = ST_DONE;
            2'd2:    state_d = ST_RD_PTR;
            default: state_d = ST_RD_OP;
          endcase
        end
      end
      ST_RD_PTR: state_d = ST_WT_PTR;
      ST_WT_PTR: state_d = ST_RD_OP;
      ST_RD_OP:  state_d = ST_WT_OP;
      ST_WT_OP:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign issue       = (state_q == ST_RD_PTR) || (state_q == ST_RD_OP);
  assign ptr_capture = (state_q == ST_WT_PTR);
  assign op_capture  = (state_q == ST_WT_OP);
  assign done        = (state_q == ST_DONE);
  assign busy        = (state_q != ST_IDLE);

endmodule

// File: rtl/oau_result.sv
module oau_result #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          ptr_capture,
  input  logic          op_capture,
  input  logic          addr_is_ea,
  input  logic [DW-1:0] first_addr,
  input  logic [DW-1:0] early_operand,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] ea_q,
  output logic [DW-1:0] op_q
);

  // addr_q drives the memory; ea_q is the reported address (0 for no-access modes)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ea_q   <= '0;
      op_q   <= '0;
    end else if (accept) begin
      addr_q <= first_addr;
      ea_q   <= addr_is_ea ? first_addr : '0;
      op_q   <= early_operand;
    end else begin
      if (ptr_capture) begin
        addr_q <= mem_rdata;
        ea_q   <= mem_rdata;
      end
      if (op_capture) op_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] req_afield,
  input  logic [RW-1:0] req_rsel,
  input  logic [DW-1:0] req_pc,
  output logic          busy,
  output logic [RW-1:0] rf_rsel,
  input  logic [DW-1:0] rf_rdata,
  output logic          mem_re,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] operand
);

  logic [DW-1:0]      first_addr;
  logic [DW-1:0]      early_operand;
  logic [READS_W-1:0] reads_needed;
  logic               accept;
  logic               issue;
  logic               ptr_capture;
  logic               op_capture;
  logic               addr_is_ea;
  logic [DW-1:0]      addr_q;

  assign rf_rsel    = req_rsel;
  assign addr_is_ea = (reads_needed == 2'd1);

  oau_ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode          (req_mode),
    .afield        (req_afield),
    .rval          (rf_rdata),
    .pc            (req_pc),
    .first_addr    (first_addr),
    .early_operand (early_operand),
    .reads_needed  (reads_needed)
  );

  oau_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .reads_needed (reads_needed),
    .accept       (accept),
    .issue        (issue),
    .ptr_capture  (ptr_capture),
    .op_capture   (op_capture),
    .done         (done),
    .busy         (busy)
  );

  oau_result #(.DW(DW)) u_res (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .ptr_capture   (ptr_capture),
    .op_capture    (op_capture),
    .addr_is_ea    (addr_is_ea),
    .first_addr    (first_addr),
    .early_operand (early_operand),
    .mem_rdata     (mem_rdata),
    .addr_q        (addr_q),
    .ea_q          (ea),
    .op_q          (operand)
  );

  assign mem_re   = issue;
  assign mem_addr = addr_q;

endmodule

// File: rtl/oau_checker.sv
module oau_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    req_mode,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          mem_re,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          accept,
  input logic          ptr_capture
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !done));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r10_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r11_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  a_r2_zero_access: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_mode == 3'd0 || req_mode == 3'd3)) |=> (done && !mem_re));

  a_r4_one_read_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode != 3'd0 && req_mode != 3'd3) |=> (mem_re && !done));

  a_r5_chain_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_capture |=> (mem_re && mem_addr == $past(mem_rdata)));

endmodule

bind opnd_addr_unit oau_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_mode    (req_mode),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .mem_re      (mem_re),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .accept      (accept),
  .ptr_capture (ptr_capture)
);

// File: tb/sim_opnd_addr_unit.sv
`timescale 1ns/1ps
module sim_opnd_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [7:0]  req_afield = '0;
  logic [2:0]  req_rsel = '0;
  logic [15:0] req_pc = '0;
  logic        busy, mem_re, done;
  logic [2:0]  rf_rsel;
  logic [15:0] rf_rdata, mem_addr, ea, operand;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  opnd_addr_unit u0 (.*);

  int regs [8];
  assign rf_rdata = 16'(regs[rf_rsel]);

  function automatic int memf(int a);
    return ((a ^ 'hA5C3) + ((a & 255) * 256 + (a >> 8))) & 'hFFFF;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= 16'(memf(int'(mem_addr)));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  int exp_done = -10, acc_cyc = -10;
  int exp_ea, exp_op, exp_reads, rd_cnt;
  int dropped = 0;
  string cur_tag = "R1";
  bit running = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, expv);
    end
  endtask

  function automatic int sx(int a);
    return (a >= 128) ? a - 256 : a;
  endfunction

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (running) begin
      bit ed, eb;
      ed = (cyc == exp_done);
      eb = (cyc >= acc_cyc) && (cyc <= exp_done);
      if (mem_re) rd_cnt++;
      chk(done == ed, cur_tag, "done", int'(done), int'(ed));
      chk(busy == eb, cur_tag, "busy", int'(busy), int'(eb));
      if (!eb) chk(!mem_re, "R1", "mem_re while idle", int'(mem_re), 0);
      if (ed) begin
        chk(int'(ea) == exp_ea, cur_tag, "ea", int'(ea), exp_ea);
        chk(int'(operand) == exp_op, cur_tag, "operand", int'(operand), exp_op);
        chk(rd_cnt == exp_reads, cur_tag, "read count", rd_cnt, exp_reads);
      end
    end
  end

  task automatic send(input int m, input int a, input int r, input int pc, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_mode = 3'(m); req_afield = 8'(a);
    req_rsel = 3'(r); req_pc = 16'(pc);
    if (cyc > exp_done) begin
      int lat;
      exp_reads = (m == 0 || m == 3) ? 0 : (m == 2 ? 2 : 1);
      case (m)
        0: begin exp_ea = 0; exp_op = a; end
        3: begin exp_ea = 0; exp_op = regs[r]; end
        1: exp_ea = a;
        2: exp_ea = memf(a);
        4: exp_ea = regs[r];
        5: exp_ea = (regs[r] + sx(a)) & 'hFFFF;
        6: exp_ea = (pc + sx(a)) & 'hFFFF;
        default: exp_ea = (regs[r] + a) & 'hFFFF;
      endcase
      if (exp_reads != 0) exp_op = memf(exp_ea);
      lat = 1 + 2 * exp_reads;
      acc_cyc = cyc + 1;
      exp_done = cyc + lat;
      rd_cnt = 0;
      cur_tag = tag;
    end else begin
      dropped++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (cyc <= exp_done + 1) @(posedge clk);
    #1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    regs[0] = 'h0000; regs[1] = 'h1000; regs[2] = 'h0005; regs[3] = 'hFFF0;
    regs[4] = 'h8000; regs[5] = 'h1234; regs[6] = 'h7FFF; regs[7] = 'h00C0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_re, "R1", "reset state", {busy, done, mem_re}, 0);
    running = 1;

    send(0, 'hFF, 0, 0, "R2");          wait_idle();
    send(3, 0, 5, 0, "R3");             wait_idle();
    send(1, 'h80, 0, 0, "R4");          wait_idle();
    send(2, 'h10, 0, 0, "R5");          wait_idle();
    chk(exp_ea > 255, "R5", "pointer beyond field range", exp_ea, 256);
    send(4, 0, 4, 0, "R6");             wait_idle();
    send(5, 'hF0, 2, 0, "R7");          wait_idle();
    chk(int'(ea) == 'hFFF5, "R7", "negative displacement wrap", int'(ea), 'hFFF5);
    send(6, 'h10, 0, 'hFFF8, "R8");     wait_idle();
    chk(int'(ea) == 'h0008, "R8", "relative wrap", int'(ea), 'h0008);
    send(6, 'h80, 0, 'h0100, "R8");     wait_idle();
    send(7, 'hF0, 1, 0, "R9");          wait_idle();
    chk(int'(ea) == 'h10F0, "R9", "base zero-extended", int'(ea), 'h10F0);
    send(7, 'h20, 3, 0, "R9");          wait_idle();

    // R10: requests while busy are dropped, result of the first stands
    send(2, 'h33, 0, 0, "R10");
    send(0, 'h01, 0, 0, "R10");
    send(3, 0, 6, 0, "R10");
    wait_idle();
    chk(int'(ea) == memf('h33), "R10", "ea after dropped requests", int'(ea), memf('h33));
    chk(dropped == 2, "R10", "dropped request count", dropped, 2);

    // R11 and general: back-to-back and random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 250; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(int'(lf[2:0]), int'(lf[15:8]), int'(lf[5:3]), int'({lf[7:0], lf[15:8]}), "R11");
      repeat (int'(lf[7:6]) + int'(lf[9])) @(posedge clk);
    end
    wait_idle();
    repeat (3) @(posedge clk);

    running = 0;
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule